// File: doc/BRIEF.md
# Password Sector Access Controller

This block decides whether a block-level read or write into a 64-sector memory is permitted. Each sector holds one security status byte. The byte has three parts: a lock flag, a two-bit read/write mode, and a two-bit link that ties the sector to one of three 32-bit passwords. The controller keeps a per-password "presented" state. At most one password is presented at a time, and all presented state clears on reset.

Requests arrive one per cycle on a single command port. Each request is either an access check or one of three security commands: lock a sector, present a password, or change a password. Every request gets a registered response in the following cycle. The response carries a pass/fail flag, an error code, and the addressed sector's status byte as it stands after the request. The status bytes and password values are held in flip-flops. Storage timing and air-interface framing belong to other blocks.

Top module: `sector_access_ctrl`

## Requirements
- R1: After reset, every status byte reads 00h, all three passwords hold 00000000h, and presented_o is 000. Each request with req_valid_i high produces exactly one response, with rsp_valid_o high in the next cycle.
- R2: The sector index is block address bits 10:5. Status byte layout: bit 0 is the lock flag, bits 2:1 are the mode, bits 4:3 are the link (00 = no password, 01/10/11 = password 1/2/3), and bits 7:5 read as zero.
- R3: An access check (op 0 = read, op 1 = write) to a sector whose lock flag is 0 always passes.
- R4: For a locked sector, the rights are as follows (password presented / not presented): mode 00 gives RW / R only; mode 01 gives RW / RW; mode 10 gives RW / none; mode 11 gives R only / none.
- R5: A locked sector with link 00 always takes the "not presented" rights.
- R6: Lock (op 2) writes req_data_i[3:0] into status bits 4:1 and sets bit 0. If the sector is already locked, the command returns error 2 and leaves the byte unchanged.
- R7: Present (op 3) with req_data_i equal to the stored value of password req_psel_i passes. Afterwards only that password is presented; any earlier one is dropped.
- R8: A present with a mismatching value returns error 3 and clears every presented bit.
- R9: Set-password (op 4) stores req_data_i as password req_psel_i only while that password is presented, and the new value is in force from the next request. Otherwise it returns error 4 and stores nothing.
- R10: A denied access check returns error 1. A response with rsp_ok_o high carries error 0.
- R11: Password index 0 on op 3 or op 4 returns error 5 and changes no state. Op codes 5 to 7 return error 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | 0 read, 1 write, 2 lock, 3 present, 4 set password |
| req_addr_i | input | 11 | Block address |
| req_psel_i | input | 2 | Password index 1..3 |
| req_data_i | input | 32 | Password value, or lock bits in [3:0] |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_ok_o | output | 1 | Request granted / command accepted |
| rsp_err_o | output | 3 | Error code |
| rsp_sss_o | output | 8 | Addressed sector status byte after the request |
| presented_o | output | 3 | Presented state per password |

## Verification
The assertions assume that req_op_i is held steady while req_valid_i is high, and that nothing outside the request port alters the presented state. Their checks of the response against the previous cycle's opcode rely on requests being sampled once per edge. The bench drives each request for a single cycle on the falling edge. It then returns req_valid_i low before it samples the response, so that every response maps to exactly one request and no response overlaps another.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_LOCK    = 3'd2,
    OP_PRESENT = 3'd3,
    OP_SETPWD  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_DENIED = 3'd1,
    ERR_LOCKED = 3'd2,
    ERR_BADPWD = 3'd3,
    ERR_NOAUTH = 3'd4,
    ERR_BADIDX = 3'd5,
    ERR_BADOP  = 3'd6
  } err_e;

  typedef struct packed {
    logic [2:0] spare;
    logic [1:0] link;
    logic [1:0] mode;
    logic       lock;
  } sss_t;

  function automatic sss_t sss_locked(input logic [3:0] cfg);
    sss_t s;
    s.spare = 3'b000;
    s.link  = cfg[3:2];
    s.mode  = cfg[1:0];
    s.lock  = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/sac_sss_store.sv
module sac_sss_store
  import sac_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] rd_idx_i,
  output sss_t             rd_byte_o,
  input  logic             wr_en_i,
  input  logic [SEC_W-1:0] wr_idx_i,
  input  sss_t             wr_byte_i
);

  sss_t mem_q [NUM_SECTORS];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sector
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == SEC_W'(g))) begin
        mem_q[g] <= wr_byte_i;
      end
    end
  end

  assign rd_byte_o = mem_q[rd_idx_i];

endmodule

// File: rtl/sac_pwd_bank.sv
module sac_pwd_bank #(
  parameter int NUM_PWD = 3,
  parameter int PWD_W   = 32,
  parameter int PSEL_W  = $clog2(NUM_PWD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSEL_W-1:0] sel_i,
  input  logic [PWD_W-1:0]  cmp_val_i,
  output logic              sel_ok_o,
  output logic              match_o,
  output logic              sel_presented_o,
  input  logic              grant_i,
  input  logic              revoke_i,
  input  logic              store_i,
  output logic [NUM_PWD-1:0] presented_o
);

  logic [PWD_W-1:0]   pwd_q [NUM_PWD];
  logic [NUM_PWD-1:0] pres_q;
  logic [NUM_PWD-1:0] sel_hot;

  for (genvar g = 0; g < NUM_PWD; g++) begin : g_pwd
    assign sel_hot[g] = (sel_i == PSEL_W'(g + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pwd_q[g] <= '0;
      end else if (store_i && sel_hot[g]) begin
        pwd_q[g] <= cmp_val_i;
      end
    end
  end

  always_comb begin
    match_o = 1'b0;
    for (int i = 0; i < NUM_PWD; i++) begin
      if (sel_hot[i] && (pwd_q[i] == cmp_val_i)) match_o = 1'b1;
    end
  end

  assign sel_ok_o        = |sel_hot;
  assign sel_presented_o = |(sel_hot & pres_q);

  // a grant replaces any earlier presentation; a revoke wipes all
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= '0;
    end else if (revoke_i) begin
      pres_q <= '0;
    end else if (grant_i) begin
      pres_q <= sel_hot;
    end
  end

  assign presented_o = pres_q;

endmodule

// File: rtl/sac_rights.sv
module sac_rights
  import sac_pkg::*;
#(
  parameter int NUM_PWD = 3
) (
  input  sss_t               sss_i,
  input  logic [NUM_PWD-1:0] presented_i,
  output logic               rd_ok_o,
  output logic               wr_ok_o
);

  logic linked_hit;

  always_comb begin
    linked_hit = 1'b0;
    for (int i = 0; i < NUM_PWD; i++) begin
      if ((sss_i.link == 2'(i + 1)) && presented_i[i]) linked_hit = 1'b1;
    end
  end

  always_comb begin
    if (!sss_i.lock) begin
      rd_ok_o = 1'b1;
      wr_ok_o = 1'b1;
    end else begin
      unique case (sss_i.mode)
        2'b00: begin rd_ok_o = 1'b1;       wr_ok_o = linked_hit; end
        2'b01: begin rd_ok_o = 1'b1;       wr_ok_o = 1'b1;       end
        2'b10: begin rd_ok_o = linked_hit; wr_ok_o = linked_hit; end
        default: begin rd_ok_o = linked_hit; wr_ok_o = 1'b0;     end
      endcase
    end
  end

endmodule

// File: rtl/sector_access_ctrl.sv
module sector_access_ctrl
  import sac_pkg::*;
#(
  parameter int NUM_SECTORS       = 64,
  parameter int BLOCKS_PER_SECTOR = 32,
  parameter int NUM_PWD           = 3,
  parameter int PWD_W             = 32,
  parameter int SEC_W             = $clog2(NUM_SECTORS),
  parameter int ADDR_W            = SEC_W + $clog2(BLOCKS_PER_SECTOR),
  parameter int PSEL_W            = $clog2(NUM_PWD + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [PSEL_W-1:0]  req_psel_i,
  input  logic [PWD_W-1:0]   req_data_i,
  output logic               rsp_valid_o,
  output logic               rsp_ok_o,
  output logic [2:0]         rsp_err_o,
  output logic [7:0]         rsp_sss_o,
  output logic [NUM_PWD-1:0] presented_o
);

  logic [SEC_W-1:0] sector;
  sss_t             cur_sss, new_sss;
  logic             sss_we;
  logic             rd_ok, wr_ok;
  logic             sel_ok, match, sel_pres;
  logic             grant, revoke, store;
  err_e             err_d;

  assign sector = req_addr_i[ADDR_W-1 -: SEC_W];

  sac_sss_store #(
    .NUM_SECTORS(NUM_SECTORS),
    .SEC_W      (SEC_W)
  ) u_sss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (sector),
    .rd_byte_o(cur_sss),
    .wr_en_i  (sss_we),
    .wr_idx_i (sector),
    .wr_byte_i(new_sss)
  );

  sac_pwd_bank #(
    .NUM_PWD(NUM_PWD),
    .PWD_W  (PWD_W),
    .PSEL_W (PSEL_W)
  ) u_pwd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sel_i          (req_psel_i),
    .cmp_val_i      (req_data_i),
    .sel_ok_o       (sel_ok),
    .match_o        (match),
    .sel_presented_o(sel_pres),
    .grant_i        (grant),
    .revoke_i       (revoke),
    .store_i        (store),
    .presented_o    (presented_o)
  );

  sac_rights #(
    .NUM_PWD(NUM_PWD)
  ) u_rights (
    .sss_i      (cur_sss),
    .presented_i(presented_o),
    .rd_ok_o    (rd_ok),
    .wr_ok_o    (wr_ok)
  );

  assign new_sss = sss_locked(req_data_i[3:0]);

  always_comb begin
    err_d  = ERR_NONE;
    sss_we = 1'b0;
    grant  = 1'b0;
    revoke = 1'b0;
    store  = 1'b0;
    if (req_valid_i) begin
      unique case (req_op_i)
        OP_READ:  if (!rd_ok) err_d = ERR_DENIED;
        OP_WRITE: if (!wr_ok) err_d = ERR_DENIED;
        OP_LOCK: begin
          if (cur_sss.lock) err_d = ERR_LOCKED;
          else              sss_we = 1'b1;
        end
        OP_PRESENT: begin
          if (!sel_ok) begin
            err_d = ERR_BADIDX;
          end else if (match) begin
            grant = 1'b1;
          end else begin
            revoke = 1'b1;
            err_d  = ERR_BADPWD;
          end
        end
        OP_SETPWD: begin
          if (!sel_ok)        err_d = ERR_BADIDX;
          else if (!sel_pres) err_d = ERR_NOAUTH;
          else                store = 1'b1;
        end
        default: err_d = ERR_BADOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= '0;
      rsp_sss_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_ok_o    <= req_valid_i && (err_d == ERR_NONE);
      rsp_err_o   <= err_d;
      rsp_sss_o   <= sss_we ? new_sss : cur_sss;
    end
  end

endmodule

// File: rtl/sector_access_ctrl_chk.sv
module sector_access_ctrl_chk #(
  parameter int NUM_PWD = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [2:0]         req_op_i,
  input logic               rsp_valid_o,
  input logic               rsp_ok_o,
  input logic [2:0]         rsp_err_o,
  input logic [7:0]         rsp_sss_o,
  input logic [NUM_PWD-1:0] presented_o
);

  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r1_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r3_unlocked_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_sss_o[0] && ($past(req_op_i) <= 3'd1)) |-> rsp_ok_o);

  a_r6_lock_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && ($past(req_op_i) == 3'd2)) |-> rsp_sss_o[0]);

  a_r7_single_presented: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(presented_o));

  a_r7_presented_held_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(presented_o));

  a_r8_bad_present_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_err_o == 3'd3)) |-> (presented_o == '0));

  a_r10_ok_has_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok_o |-> (rsp_err_o == 3'd0));

endmodule

bind sector_access_ctrl sector_access_ctrl_chk #(.NUM_PWD(NUM_PWD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_op_i   (req_op_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ok_o   (rsp_ok_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_sss_o  (rsp_sss_o),
  .presented_o(presented_o)
);

// File: tb/sector_access_ctrl_tb.sv
module sector_access_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [10:0] req_addr = '0;
  logic [1:0]  req_psel = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid, rsp_ok;
  logic [2:0]  rsp_err;
  logic [7:0]  rsp_sss;
  logic [2:0]  presented;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sector_access_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_op_i   (req_op),
    .req_addr_i (req_addr),
    .req_psel_i (req_psel),
    .req_data_i (req_data),
    .rsp_valid_o(rsp_valid),
    .rsp_ok_o   (rsp_ok),
    .rsp_err_o  (rsp_err),
    .rsp_sss_o  (rsp_sss),
    .presented_o(presented)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one-cycle request; response sampled at the following falling edge
  task automatic req(input logic [2:0] op, input logic [10:0] addr,
                     input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_psel = sel; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
  endtask

  task automatic expect_rsp(input string tag, input logic [2:0] err, input logic [7:0] sss);
    chk({tag, " err"}, 32'(rsp_err), 32'(err));
    chk({tag, " ok"},  32'(rsp_ok),  32'(err == 3'd0));
    chk({tag, " sss"}, 32'(rsp_sss), 32'(sss));
  endtask

  task automatic t_reset;
    chk("R1 presented after reset", 32'(presented), 32'd0);
    chk("R1 idle no rsp", 32'(rsp_valid), 32'd0);
    req(3'd0, 11'd160, 2'd0, 0); expect_rsp("R1 R3 read unlocked", 3'd0, 8'h00);
    req(3'd1, 11'd161, 2'd0, 0); expect_rsp("R3 write unlocked", 3'd0, 8'h00);
  endtask

  task automatic t_lock_basic;
    req(3'd2, 11'd32, 2'd0, 32'h4); expect_rsp("R6 lock s1", 3'd0, 8'h09);
    req(3'd0, 11'd33, 2'd0, 0);     expect_rsp("R4 s1 mode00 read", 3'd0, 8'h09);
    req(3'd1, 11'd33, 2'd0, 0);     expect_rsp("R10 s1 write denied", 3'd1, 8'h09);
  endtask

  task automatic t_relock;
    req(3'd2, 11'd40, 2'd0, 32'h7); expect_rsp("R6 relock", 3'd2, 8'h09);
    req(3'd1, 11'd63, 2'd0, 0);     expect_rsp("R6 s1 unchanged", 3'd1, 8'h09);
  endtask

  task automatic t_present;
    req(3'd3, 11'd0, 2'd1, 32'h0);  expect_rsp("R7 present p1", 3'd0, 8'h00);
    chk("R7 presented p1", 32'(presented), 32'd1);
    req(3'd1, 11'd33, 2'd0, 0);     expect_rsp("R4 s1 write with p1", 3'd0, 8'h09);
  endtask

  task automatic t_modes;
    req(3'd2, 11'd64, 2'd0, 32'h7); expect_rsp("R6 lock s2", 3'd0, 8'h0F);
    req(3'd0, 11'd64, 2'd0, 0);     expect_rsp("R4 mode11 read", 3'd0, 8'h0F);
    req(3'd1, 11'd64, 2'd0, 0);     expect_rsp("R4 mode11 write", 3'd1, 8'h0F);
    req(3'd2, 11'd96, 2'd0, 32'h6); expect_rsp("R6 lock s3", 3'd0, 8'h0D);
    req(3'd1, 11'd96, 2'd0, 0);     expect_rsp("R4 mode10 write", 3'd0, 8'h0D);
  endtask

  task automatic t_passwords;
    req(3'd4, 11'd0, 2'd1, 32'hCAFE_F00D); expect_rsp("R9 set p1", 3'd0, 8'h00);
    chk("R9 p1 kept", 32'(presented), 32'd1);
    req(3'd3, 11'd0, 2'd2, 32'h1);  expect_rsp("R8 wrong p2", 3'd3, 8'h00);
    chk("R8 all cleared", 32'(presented), 32'd0);
    req(3'd1, 11'd33, 2'd0, 0);     expect_rsp("R8 s1 write revoked", 3'd1, 8'h09);
    req(3'd0, 11'd96, 2'd0, 0);     expect_rsp("R8 s3 read revoked", 3'd1, 8'h0D);
    req(3'd4, 11'd0, 2'd1, 32'h5);  expect_rsp("R9 set unauth", 3'd4, 8'h00);
    req(3'd3, 11'd0, 2'd1, 32'h0);  expect_rsp("R9 old value rejected", 3'd3, 8'h00);
    req(3'd3, 11'd0, 2'd1, 32'hCAFE_F00D); expect_rsp("R9 new value works", 3'd0, 8'h00);
    chk("R9 p1 presented", 32'(presented), 32'd1);
  endtask

  task automatic t_unlinked;
    req(3'd2, 11'd128, 2'd0, 32'h1); expect_rsp("R5 lock s4", 3'd0, 8'h03);
    req(3'd1, 11'd128, 2'd0, 0);     expect_rsp("R5 mode01 write", 3'd0, 8'h03);
    req(3'd2, 11'd160, 2'd0, 32'h2); expect_rsp("R5 lock s5", 3'd0, 8'h05);
    req(3'd0, 11'd191, 2'd0, 0);     expect_rsp("R5 mode10 unlinked read", 3'd1, 8'h05);
  endtask

  task automatic t_switch;
    req(3'd3, 11'd0, 2'd2, 32'h0);  expect_rsp("R7 present p2", 3'd0, 8'h00);
    chk("R7 p1 dropped", 32'(presented), 32'd2);
    req(3'd0, 11'd96, 2'd0, 0);     expect_rsp("R7 s3 lost rights", 3'd1, 8'h0D);
  endtask

  task automatic t_badidx;
    req(3'd3, 11'd0, 2'd0, 32'h0);  expect_rsp("R11 present idx0", 3'd5, 8'h00);
    chk("R11 presented kept", 32'(presented), 32'd2);
    req(3'd4, 11'd0, 2'd0, 32'h0);  expect_rsp("R11 set idx0", 3'd5, 8'h00);
    req(3'd6, 11'd32, 2'd1, 32'h0); expect_rsp("R11 bad op", 3'd6, 8'h09);
  endtask

  task automatic t_addr;
    req(3'd2, 11'd2047, 2'd0, 32'hB); expect_rsp("R2 lock s63", 3'd0, 8'h17);
    req(3'd1, 11'd2016, 2'd0, 0);     expect_rsp("R2 s63 write", 3'd1, 8'h17);
    req(3'd0, 11'd2016, 2'd0, 0);     expect_rsp("R2 s63 read", 3'd0, 8'h17);
    req(3'd1, 11'd2015, 2'd0, 0);     expect_rsp("R2 s62 write", 3'd0, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lock_basic;
    t_relock;
    t_present;
    t_modes;
    t_passwords;
    t_unlinked;
    t_switch;
    t_badidx;
    t_addr;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

endmodule